// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one channel of a DMA controller. Software-facing logic elsewhere programs a control word, a source address, a destination address and a cycle count. A rising edge on the enable input starts a run. The engine then moves data one beat at a time: it reads a unit from the source, then writes that unit to the destination. After each beat it steps both addresses by the amounts the control word selects.

A counted cycle holds one beat. In burst mode it holds four beats, so a 64-byte word transfer in burst mode takes four cycles. The remaining cycle count is visible at all times. A driver can use it to work out how much of a run is still to be moved.

A run can be paced by a peripheral. The control word names a request line for the source side and one for the destination side. When either is non-zero, every cycle waits for that line's request and answers with a single-clock grant. When both are zero, the channel runs free. The block raises a one-clock done pulse when a run completes and a one-clock error pulse when a run is refused.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, busy, done, err, mem_valid and every gnt bit are 0, and cnt_left is 0.
- R2: Control bits 21:20 give the unit width: 00 is 4 bytes, 01 is 2 bytes and 10 is 1 byte. mem_size shows it as 2, 1 and 0 respectively. Each beat reads one unit from the source address and then writes the same unit, unchanged, to the destination address.
- R3: The source step code is control bits 10:8 and the destination step code is control bits 14:12. After each beat the address moves by the code: 000 holds it, 001/010/011 add 1/2/4 bytes, and 101/110/111 subtract 1/2/4 bytes.
- R4: When control bit 3 is set (burst), one counted cycle is four beats, so each address moves four times its code per cycle. When bit 3 is clear, a cycle is one beat.
- R5: cnt_left is loaded with the programmed count at start. It drops by one as each cycle's last write completes, so it always equals the programmed count minus the completed cycles.
- R6: When the count reaches zero the engine returns to idle (busy low) and pulses done for exactly one clock.
- R7: A run starts only on a rising edge of en. A run started with a count of zero pulses done in the clock after the start edge and makes no memory access.
- R8: A width code of 11, or a step code of 100 on either side, is refused at start. The engine pulses err for one clock, makes no memory access and gives no done pulse.
- R9: The source request line number is control bits 27:24 and the destination request line number is control bits 19:16. The source number is used when it is non-zero; otherwise the destination number is used. Line n uses dreq[n-1] and gnt[n-1]. A non-zero line makes every cycle wait for its request, then give a one-clock grant, then start the cycle's first read. Line 0 means no waiting and no grants.
- R10: The memory port is valid/ready. A transfer completes in a clock where mem_valid and mem_ready are both high. While mem_valid is high and mem_ready is low, mem_valid stays high and mem_addr, mem_we and mem_wdata stay stable. Read data is taken from mem_rdata in the completing clock.
- R11: Clearing en during a run lets the current beat finish its write, then returns to idle with no done pulse. cnt_left keeps the cycles not yet completed. Clearing en while waiting for a request stops at once.
- R12: mem_ahb equals control bit 6 during reads and control bit 7 during writes (1 selects the high-speed bus side, 0 the peripheral bus side).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Channel enable; rising edge starts a run, low stops it |
| ctrl | input | 32 | Control word, sampled at start |
| src_addr | input | AW | Start source byte address |
| dst_addr | input | AW | Start destination byte address |
| cycles | input | CW | Programmed cycle count |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-clock pulse at run completion |
| err | output | 1 | One-clock pulse when a run is refused |
| cnt_left | output | CW | Remaining cycle count |
| dreq | input | NL | Peripheral request lines |
| gnt | output | NL | Peripheral grant pulses |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted / completed |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_ahb | output | 1 | Bus side of the current access |
| mem_size | output | 2 | log2 of the unit size in bytes |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data, unit in the low bits |
| mem_rdata | input | 32 | Read data, unit in the low bits |

## Verification
The checks assume that en rises only while the engine is idle, with the idle gap at least one clock long. They also assume the memory side never raises mem_ready when no request is pending, and that the request line in use eventually rises. The bench holds en low between runs and raises mem_ready only in answer to a visible mem_valid. It drives only the selected request line and asserts it at random with a non-zero probability. Control words in the random runs are built field by field, so reserved codes appear only in the directed refusal cases.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_GRANT,
    ST_RD,
    ST_WR
  } xfer_state_t;

  typedef struct packed {
    logic [1:0] width;
    logic       burst;
    logic [2:0] src_step;
    logic [2:0] dst_step;
    logic       src_fast;
    logic       dst_fast;
    logic [3:0] src_line;
    logic [3:0] dst_line;
  } xfer_cfg_t;

  localparam logic [1:0] WIDTH_RSVD = 2'b11;
  localparam logic [2:0] STEP_RSVD  = 3'b100;

endpackage

// File: rtl/dma_cfg_decode.sv
module dma_cfg_decode
  import dma_xfer_pkg::*;
(
  input  logic [31:0] ctrl,
  output xfer_cfg_t   cfg,
  output logic        bad
);

  logic unused_ctrl;

  always_comb begin
    cfg.width    = ctrl[21:20];
    cfg.burst    = ctrl[3];
    cfg.src_step = ctrl[10:8];
    cfg.dst_step = ctrl[14:12];
    cfg.src_fast = ctrl[6];
    cfg.dst_fast = ctrl[7];
    cfg.src_line = ctrl[27:24];
    cfg.dst_line = ctrl[19:16];
  end

  assign bad = (cfg.width == WIDTH_RSVD) ||
               (cfg.src_step == STEP_RSVD) ||
               (cfg.dst_step == STEP_RSVD);

  assign unused_ctrl = ^{ctrl[31:28], ctrl[23:22], ctrl[15], ctrl[11],
                         ctrl[5:4], ctrl[2:0]};

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] init,
  input  logic          adv,
  input  logic [2:0]    code,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] mag;

  always_comb begin
    case (code[1:0])
      2'b01:   mag = AW'(1);
      2'b10:   mag = AW'(2);
      2'b11:   mag = AW'(4);
      default: mag = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (load) begin
      addr <= init;
    end else if (adv) begin
      addr <= code[2] ? addr - mag : addr + mag;
    end
  end

endmodule

// File: rtl/dma_pacer.sv
module dma_pacer #(
  parameter int NL = 15
) (
  input  logic [3:0]    src_line,
  input  logic [3:0]    dst_line,
  input  logic [NL-1:0] dreq,
  input  logic          grant_now,
  output logic          paced,
  output logic          req_hit,
  output logic [NL-1:0] gnt
);

  logic [3:0] line;

  assign line  = (src_line != 4'd0) ? src_line : dst_line;
  assign paced = (line != 4'd0);

  always_comb begin
    req_hit = 1'b0;
    for (int i = 0; i < NL; i++) begin
      if ((line == 4'(i + 1)) && dreq[i]) req_hit = 1'b1;
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_gnt
    assign gnt[g] = grant_now && (line == 4'(g + 1));
  end

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int AW          = 32,
  parameter int CW          = 24,
  parameter int NL          = 15,
  parameter int BURST_BEATS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [31:0]   ctrl,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [CW-1:0] cycles,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [CW-1:0] cnt_left,
  input  logic [NL-1:0] dreq,
  output logic [NL-1:0] gnt,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic          mem_ahb,
  output logic [1:0]    mem_size,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);

  localparam int BTW = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;
  localparam logic [BTW-1:0] BEAT_LAST = BTW'(BURST_BEATS - 1);

  xfer_state_t   state;
  xfer_cfg_t     cfg_in, cfg_q;
  logic          cfg_bad;
  logic          en_q;
  logic          start;
  logic          start_run;
  logic          paced_in;
  logic          paced;
  logic          req_hit;
  logic [BTW-1:0] beat;
  logic          beat_last;
  logic [CW-1:0] cnt;
  logic [31:0]   rbuf;
  logic [AW-1:0] src_cur, dst_cur;
  logic          rd_fire, wr_fire;

  dma_cfg_decode u_dec (
    .ctrl (ctrl),
    .cfg  (cfg_in),
    .bad  (cfg_bad)
  );

  assign start     = en && !en_q && (state == ST_IDLE);
  assign start_run = start && !cfg_bad && (cycles != '0);
  assign paced_in  = (cfg_in.src_line != 4'd0) || (cfg_in.dst_line != 4'd0);
  assign rd_fire   = (state == ST_RD) && mem_ready;
  assign wr_fire   = (state == ST_WR) && mem_ready;
  assign beat_last = cfg_q.burst ? (beat == BEAT_LAST) : 1'b1;

  dma_addr_gen #(.AW(AW)) u_src (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_run),
    .init  (src_addr),
    .adv   (rd_fire),
    .code  (cfg_q.src_step),
    .addr  (src_cur)
  );

  dma_addr_gen #(.AW(AW)) u_dst (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_run),
    .init  (dst_addr),
    .adv   (wr_fire),
    .code  (cfg_q.dst_step),
    .addr  (dst_cur)
  );

  dma_pacer #(.NL(NL)) u_pace (
    .src_line  (cfg_q.src_line),
    .dst_line  (cfg_q.dst_line),
    .dreq      (dreq),
    .grant_now (state == ST_GRANT),
    .paced     (paced),
    .req_hit   (req_hit),
    .gnt       (gnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      en_q  <= 1'b0;
      cfg_q <= '0;
      cnt   <= '0;
      beat  <= '0;
      rbuf  <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      en_q <= en;
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (cfg_bad) begin
              err <= 1'b1;
            end else if (cycles == '0) begin
              cnt  <= '0;
              done <= 1'b1;
            end else begin
              cfg_q <= cfg_in;
              cnt   <= cycles;
              beat  <= '0;
              state <= paced_in ? ST_WAIT : ST_RD;
            end
          end
        end
        ST_WAIT: begin
          if (!en)          state <= ST_IDLE;
          else if (req_hit) state <= ST_GRANT;
        end
        ST_GRANT: state <= ST_RD;
        ST_RD: begin
          if (mem_ready) begin
            rbuf  <= mem_rdata;
            state <= ST_WR;
          end
        end
        ST_WR: begin
          if (mem_ready) begin
            if (beat_last) begin
              cnt  <= cnt - CW'(1);
              beat <= '0;
              if (cnt == CW'(1)) begin
                done  <= 1'b1;
                state <= ST_IDLE;
              end else if (!en) begin
                state <= ST_IDLE;
              end else begin
                state <= paced ? ST_WAIT : ST_RD;
              end
            end else begin
              beat  <= beat + BTW'(1);
              state <= en ? ST_RD : ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign cnt_left  = cnt;
  assign mem_valid = (state == ST_RD) || (state == ST_WR);
  assign mem_we    = (state == ST_WR);
  assign mem_ahb   = mem_we ? cfg_q.dst_fast : cfg_q.src_fast;
  assign mem_size  = 2'd2 - cfg_q.width;
  assign mem_addr  = mem_we ? dst_cur : src_cur;
  assign mem_wdata = rbuf;

endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int NL = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [CW-1:0] cnt_left,
  input logic [NL-1:0] dreq,
  input logic [NL-1:0] gnt,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata
);

  // R10: a pending request holds its attributes until accepted
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

  // R10: no memory access outside a run
  a_r10_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy);

  // R8: refusal and completion never coincide
  a_r8_err_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R8: error is a single pulse
  a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  // R9: at most one grant line at a time
  a_r9_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R9: grant lasts one clock
  a_r9_gnt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |=> !(|gnt));

  // R9: a grant follows a seen request on the same line
  a_r9_gnt_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |-> ($past(dreq) & gnt) != '0);

  // R9: no access in the grant clock
  a_r9_gnt_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |-> !mem_valid);

  // R5: the remaining count never rises during a run
  a_r5_cnt_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (cnt_left <= $past(cnt_left)));

  // R6: done is a single pulse, raised with the engine idle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.AW(AW), .CW(CW), .NL(NL)) u_chk (.*);

// File: tb/dma_xfer_engine_bench.sv
module dma_xfer_engine_bench;

  localparam int AW = 32;
  localparam int CW = 24;
  localparam int NL = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [31:0]   ctrl = '0;
  logic [AW-1:0] src_addr = '0;
  logic [AW-1:0] dst_addr = '0;
  logic [CW-1:0] cycles = '0;
  logic          busy, done, err;
  logic [CW-1:0] cnt_left;
  logic [NL-1:0] dreq = '0;
  logic [NL-1:0] gnt;
  logic          mem_valid, mem_we, mem_ahb;
  logic          mem_ready = 1'b0;
  logic [1:0]    mem_size;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;

  dma_xfer_engine #(.AW(AW), .CW(CW), .NL(NL)) u_dma_xfer_engine (
    .clk, .rst_n, .en, .ctrl, .src_addr, .dst_addr, .cycles,
    .busy, .done, .err, .cnt_left, .dreq, .gnt,
    .mem_valid, .mem_ready, .mem_we, .mem_ahb, .mem_size,
    .mem_addr, .mem_wdata, .mem_rdata
  );

  always #2 clk = ~clk;

  logic [7:0] mem [0:4095];
  logic [7:0] shadow [0:4095];

  int checks = 0, errors = 0;
  int wr_count, rd_count, done_count, err_count, gnt_count;
  int cnt_bad, side_bad, size_bad;
  int cur_n, cur_beats;
  logic [3:0] cur_line;
  logic cur_sfast, cur_dfast;
  logic [1:0] cur_size;
  logic pend = 1'b0;
  logic [11:0] pend_addr;
  logic [31:0] pend_data;
  logic [1:0]  pend_size;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int step_of(input logic [2:0] c);
    int m;
    case (c[1:0])
      2'b01: m = 1;
      2'b10: m = 2;
      2'b11: m = 4;
      default: m = 0;
    endcase
    return c[2] ? -m : m;
  endfunction

  function automatic logic [31:0] mk_ctrl(input logic [1:0] w, input logic b,
      input logic [2:0] sc, input logic [2:0] dc, input logic sf, input logic df,
      input logic [3:0] sl, input logic [3:0] dl);
    logic [31:0] c;
    c = '0;
    c[21:20] = w; c[3] = b; c[10:8] = sc; c[14:12] = dc;
    c[6] = sf; c[7] = df; c[27:24] = sl; c[19:16] = dl;
    return c;
  endfunction

  // memory responder and monitor
  initial begin
    forever begin
      @(negedge clk);
      if (pend) begin
        for (int k = 0; k < (1 << pend_size); k++)
          mem[12'(pend_addr + 12'(k))] = pend_data[8*k +: 8];
        pend = 1'b0;
        wr_count++;
        if (wr_count % cur_beats == 0)
          if (cnt_left !== CW'(cur_n - wr_count / cur_beats)) cnt_bad++;
      end
      if (done) done_count++;
      if (err) err_count++;
      if (|gnt) gnt_count++;
      dreq = '0;
      if (cur_line != 4'd0) dreq[cur_line - 4'd1] = ($urandom % 3 == 0);
      mem_ready = 1'b0;
      if (mem_valid) begin
        if (mem_ahb !== (mem_we ? cur_dfast : cur_sfast)) side_bad++;
        if (mem_size !== cur_size) size_bad++;
        if ($urandom % 4 != 0) begin
          mem_ready = 1'b1;
          if (mem_we) begin
            pend = 1'b1;
            pend_addr = mem_addr[11:0];
            pend_data = mem_wdata;
            pend_size = mem_size;
          end else begin
            rd_count++;
            mem_rdata = '0;
            for (int k = 0; k < (1 << mem_size); k++)
              mem_rdata[8*k +: 8] = mem[12'(mem_addr[11:0] + 12'(k))];
          end
        end
      end
    end
  end

  // reference model: nbeats beats on the shadow memory
  task automatic ref_run(input logic [31:0] c, input int s0, input int d0, input int nbeats);
    int s, d, nb;
    logic [7:0] tmp [0:3];
    s = s0; d = d0;
    nb = 1 << (2 - c[21:20]);
    for (int b = 0; b < nbeats; b++) begin
      for (int k = 0; k < nb; k++) tmp[k] = shadow[12'(s + k)];
      for (int k = 0; k < nb; k++) shadow[12'(d + k)] = tmp[k];
      s += step_of(c[10:8]);
      d += step_of(c[14:12]);
    end
  endtask

  function automatic int mem_diffs();
    int n;
    n = 0;
    for (int i = 0; i < 4096; i++) if (mem[i] !== shadow[i]) n++;
    return n;
  endfunction

  task automatic arm(input logic [31:0] c, input int s, input int d, input int n);
    @(negedge clk);
    ctrl = c; src_addr = AW'(s); dst_addr = AW'(d); cycles = CW'(n);
    cur_n = n; cur_beats = c[3] ? 4 : 1;
    cur_line = (c[27:24] != 0) ? c[27:24] : c[19:16];
    cur_sfast = c[6]; cur_dfast = c[7]; cur_size = 2'd2 - c[21:20];
    wr_count = 0; rd_count = 0; done_count = 0; err_count = 0; gnt_count = 0;
    cnt_bad = 0; side_bad = 0; size_bad = 0;
    for (int i = 0; i < 4096; i++) shadow[i] = mem[i];
    en = 1'b1;
  endtask

  task automatic wait_end();
    int t;
    t = 0;
    while (done_count == 0 && err_count == 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 5000) check(1'b0, "R6", "run timeout", t, 0);
  endtask

  task automatic normal_run(input string tag, input logic [31:0] c,
                            input int s, input int d, input int n);
    arm(c, s, d, n);
    wait_end();
    repeat (8) @(negedge clk);
    ref_run(c, s, d, n * cur_beats);
    check(done_count == 1, "R6", {tag, " done pulses"}, done_count, 1);
    check(!busy, "R7", {tag, " no restart while en high"}, busy, 0);
    check(cnt_left == 0 && cnt_bad == 0, "R5", {tag, " count readback"}, cnt_bad, 0);
    check(wr_count == n * cur_beats, "R4", {tag, " beats"}, wr_count, n * cur_beats);
    check(mem_diffs() == 0, "R3", {tag, " memory image"}, mem_diffs(), 0);
    check(size_bad == 0, "R2", {tag, " unit size"}, size_bad, 0);
    check(side_bad == 0, "R12", {tag, " bus side"}, side_bad, 0);
    if (cur_line != 0)
      check(gnt_count == n, "R9", {tag, " grants"}, gnt_count, n);
    else
      check(gnt_count == 0, "R9", {tag, " no grants"}, gnt_count, 0);
    en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic refused(input string tag, input logic [31:0] c);
    arm(c, 100, 200, 3);
    @(negedge clk);
    check(err === 1'b1, "R8", {tag, " err pulse"}, err, 1);
    repeat (10) @(negedge clk);
    check(err_count == 1 && done_count == 0, "R8", {tag, " pulses"}, done_count, 0);
    check(rd_count == 0 && wr_count == 0, "R8", {tag, " no access"}, rd_count + wr_count, 0);
    en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(4 * 190000);
    check(1'b0, "R6", "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] codes [0:6];
    void'($urandom(32'd1234));
    codes[0] = 3'b000; codes[1] = 3'b001; codes[2] = 3'b010; codes[3] = 3'b011;
    codes[4] = 3'b101; codes[5] = 3'b110; codes[6] = 3'b111;
    cur_n = 1; cur_beats = 1; cur_line = 0; cur_sfast = 0; cur_dfast = 0; cur_size = 2;
    for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !err && !mem_valid && gnt == 0 && cnt_left == 0,
          "R1", "reset outputs", {busy, done, err, mem_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4: burst word copy, 64 bytes in four cycles
    normal_run("burst word", mk_ctrl(2'b00, 1, 3'b011, 3'b011, 1, 0, 0, 0), 1024, 2048, 4);
    // R2/R3: byte copy counting down
    normal_run("byte down", mk_ctrl(2'b10, 0, 3'b101, 3'b111, 0, 1, 0, 0), 1500, 2500, 7);
    // R3: fixed destination, half words
    normal_run("hold dst", mk_ctrl(2'b01, 0, 3'b010, 3'b000, 1, 1, 0, 0), 1200, 3000, 5);
    // R9: paced on source line 3
    normal_run("paced src", mk_ctrl(2'b00, 0, 3'b011, 3'b011, 0, 0, 4'd3, 4'd9), 1800, 2200, 4);
    // R9: paced on destination line 15
    normal_run("paced dst", mk_ctrl(2'b01, 1, 3'b010, 3'b010, 0, 0, 4'd0, 4'd15), 1300, 1400, 2);

    // R7: zero count completes at once
    arm(mk_ctrl(2'b00, 0, 3'b011, 3'b011, 0, 0, 0, 0), 100, 200, 0);
    @(negedge clk);
    check(done === 1'b1, "R7", "zero count done next clock", done, 1);
    repeat (6) @(negedge clk);
    check(rd_count == 0 && wr_count == 0 && done_count == 1, "R7", "zero count no access",
          rd_count + wr_count, 0);
    en = 1'b0;
    repeat (2) @(negedge clk);

    // R8: reserved codes
    refused("width 11", mk_ctrl(2'b11, 0, 3'b001, 3'b001, 0, 0, 0, 0));
    refused("src step 100", mk_ctrl(2'b00, 0, 3'b100, 3'b001, 0, 0, 0, 0));
    refused("dst step 100", mk_ctrl(2'b10, 1, 3'b001, 3'b100, 0, 0, 0, 0));

    // R11: enable cleared mid-run
    begin
      logic [31:0] c;
      int t;
      c = mk_ctrl(2'b00, 1, 3'b011, 3'b011, 0, 0, 0, 0);
      arm(c, 2600, 3200, 4);
      t = 0;
      while (wr_count < 3 && t < 2000) begin @(negedge clk); t++; end
      en = 1'b0;
      repeat (30) @(negedge clk);
      ref_run(c, 2600, 3200, wr_count);
      check(done_count == 0 && !busy, "R11", "stopped without done", done_count, 0);
      check(wr_count >= 3 && wr_count <= 4, "R11", "beats after stop", wr_count, 4);
      check(mem_diffs() == 0, "R11", "partial image", mem_diffs(), 0);
      check(cnt_left == CW'(4 - wr_count / 4), "R5", "count kept after stop",
            cnt_left, 4 - wr_count / 4);
      repeat (2) @(negedge clk);
    end

    // R10: random mixed runs under random back-pressure
    for (int it = 0; it < 16; it++) begin
      logic [31:0] c;
      logic [3:0] ln;
      ln = ($urandom % 2 == 0) ? 4'd0 : 4'(1 + $urandom % 15);
      c = mk_ctrl(2'($urandom % 3), 1'($urandom), codes[$urandom % 7], codes[$urandom % 7],
                  1'($urandom), 1'($urandom), ($urandom % 2) ? ln : 4'd0, ln);
      normal_run("R10 random", c, 1024 + int'($urandom % 1024), 2200 + int'($urandom % 1024),
                 1 + int'($urandom % 6));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule